// File: doc/BRIEF.md
# Serial Controller Event and Interrupt-Mask Registers

This block keeps the event flags and the interrupt enables of a serial controller and turns them into one interrupt request. The controller logic sends a one-cycle pulse when it sees any of four conditions:

- a transmit error;
- an incoming character dropped because no receive buffer was free;
- the final character of a transmit buffer entering the transmit FIFO;
- the final character of a receive buffer being stored and that buffer closed.

Each pulse latches a flag in the event register.

Software reads both registers through a simple register port. It acknowledges events by writing ones to the flags it wants to clear. It enables or masks each interrupt source through the mask register. The interrupt request is the OR of every event flag whose mask bit is one. The request therefore stays asserted until software has cleared every enabled pending flag, or has masked it.

Both registers are eight bits wide. Bit numbering counts from the most significant end: field bit 0 is `rd_data[7]` and field bit 7 is `rd_data[0]`. Only four positions are implemented. The rest are reserved.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset both registers read 0x00 and `irq` is 0.
- R2: Event pulses map to fixed data bits, the same in both registers: `ev_tx_err` to `rd_data[4]` (field bit 3), `ev_rx_drop` to `rd_data[2]` (field bit 5), `ev_tx_done` to `rd_data[1]` (field bit 6) and `ev_rx_done` to `rd_data[0]` (field bit 7).
- R3: An event pulse sampled high at a rising edge sets its flag from that edge on. The flag stays set until it is cleared.
- R4: A write with `wr_sel`=0 clears each event flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R5: If an event pulse and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R6: A write with `wr_sel`=1 loads the mask. Reserved positions (data bits 7, 6, 5 and 3) always read 0 in both registers and ignore writes. Reading uses `rd_sel` (0 = events, 1 = mask), and `rd_data` follows the registers without delay.
- R7: `irq` equals the OR over implemented bits of (event AND mask). It follows the registers in the same cycle, so a mask change takes effect right after the write edge.
- R8: `irq` stays high while any enabled flag remains set, even after other flags are cleared.
- R9: Writing the mask never changes the event flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_rx_drop | input | 1 | Character dropped, no receive buffer |
| ev_tx_done | input | 1 | Last transmit character queued |
| ev_rx_done | input | 1 | Receive buffer closed |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 events (write-one-to-clear), 1 mask |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 events, 1 mask |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:

- reserved positions of both registers stay at zero;
- a pulse always leaves its flag set, including when a clear arrives in the same cycle;
- a clear with no pulse always empties the flag;
- a flag that is neither pulsed nor cleared holds its value;
- the mask holds its value between writes;
- a rise in `irq` is always preceded by a pulse or a mask write, and a fall by a clear or a mask write.

Some behaviour only the bench scenarios can show. These are the exact bit mapping seen through reads, the value of `irq` for particular mixes of flags and enables, and `irq` persisting while one of two enabled flags is cleared. They also include events left untouched by mask writes and by zero-valued clear writes.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  parameter int REG_W = 8;

  // Vector positions (field bit n sits at vector bit REG_W-1-n)
  localparam int POS_TXERR  = REG_W - 1 - 3;
  localparam int POS_RXDROP = REG_W - 1 - 5;
  localparam int POS_TXDONE = REG_W - 1 - 6;
  localparam int POS_RXDONE = REG_W - 1 - 7;

  localparam logic [REG_W-1:0] IMPL_BITS =
    (REG_W'(1) << POS_TXERR)  | (REG_W'(1) << POS_RXDROP) |
    (REG_W'(1) << POS_TXDONE) | (REG_W'(1) << POS_RXDONE);

  function automatic logic [REG_W-1:0] pack_events(input logic tx_err, input logic rx_drop,
                                                   input logic tx_done, input logic rx_done);
    logic [REG_W-1:0] v;
    v = '0;
    v[POS_TXERR]  = tx_err;
    v[POS_RXDROP] = rx_drop;
    v[POS_TXDONE] = tx_done;
    v[POS_RXDONE] = rx_done;
    return v;
  endfunction

  function automatic logic pending_any(input logic [REG_W-1:0] ev, input logic [REG_W-1:0] en);
    return |(ev & en & IMPL_BITS);
  endfunction
endpackage

// File: rtl/sirq_event_reg.sv
module sirq_event_reg
  import sirq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] IMPL = IMPL_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] ev_q
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ev_q[i] <= 1'b0;
        else if (set_vec[i]) ev_q[i] <= 1'b1;
        else if (clr_vec[i]) ev_q[i] <= 1'b0;
      end

      // R3 / R5: a pulse always leaves the flag set
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seen && set_vec[i] |=> ev_q[i]);
      // R4: clear without pulse empties the flag
      a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        seen && clr_vec[i] && !set_vec[i] |=> !ev_q[i]);
      // R4: untouched flag holds
      a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !clr_vec[i] && !set_vec[i] |=> $stable(ev_q[i]));
    end else begin : g_rsvd
      assign ev_q[i] = 1'b0;
    end
  end

  // R6: reserved flags read zero
  a_r6_ev_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & ~IMPL) == '0);
endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg
  import sirq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] IMPL = IMPL_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] mask_q
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mask_q[i] <= 1'b0;
        else if (load) mask_q[i] <= din[i];
      end
    end else begin : g_rsvd
      assign mask_q[i] = 1'b0;
    end
  end

  // R6: reserved enables read zero
  a_r6_mask_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~IMPL) == '0);
  // R6: mask holds between writes
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !load |=> $stable(mask_q));
endmodule

// File: rtl/sirq_req.sv
module sirq_req
  import sirq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] ev,
  input  logic [W-1:0] en,
  output logic         req
);
  always_comb req = pending_any(ev, en);
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_tx_err,
  input  logic             ev_rx_drop,
  input  logic             ev_tx_done,
  input  logic             ev_rx_done,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic [REG_W-1:0] set_vec, clr_vec, ev_q, mask_q;
  logic             mask_load, ev_write;

  always_comb begin
    set_vec   = pack_events(ev_tx_err, ev_rx_drop, ev_tx_done, ev_rx_done);
    ev_write  = wr_en && !wr_sel;
    mask_load = wr_en && wr_sel;
    clr_vec   = ev_write ? wr_data : '0;
  end

  sirq_event_reg #(.W(REG_W), .IMPL(IMPL_BITS)) u_ev (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .ev_q(ev_q));

  sirq_mask_reg #(.W(REG_W), .IMPL(IMPL_BITS)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(mask_load), .din(wr_data), .mask_q(mask_q));

  sirq_req #(.W(REG_W)) u_req (.ev(ev_q), .en(mask_q), .req(irq));

  always_comb rd_data = rd_sel ? mask_q : ev_q;

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R7 / R8: irq only rises after a pulse or mask write, only falls after a clear or mask write
  a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $rose(irq) |-> $past(|set_vec || mask_load));
  a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $fell(irq) |-> $past(ev_write || mask_load));
  // R9: a mask write with no pulse or clear leaves events alone
  a_r9_mask_keeps_ev: assert property (@(posedge clk) disable iff (!rst_n)
    seen && mask_load && set_vec == '0 |=> $stable(ev_q));
endmodule

// File: tb/sim_sirq_ctrl.sv
module sim_sirq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_tx_err = 0, ev_rx_drop = 0, ev_tx_done = 0, ev_rx_done = 0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;

  always #2.5 clk = ~clk;

  sirq_ctrl u0 (.clk(clk), .rst_n(rst_n), .ev_tx_err(ev_tx_err), .ev_rx_drop(ev_rx_drop),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  typedef struct { logic [7:0] data; logic irq; string tag; } item_t;
  item_t sb[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_ev = '0, m_mk = '0;
  localparam logic [7:0] IMPL = 8'h17;
  function automatic logic m_irq();
    return (m_ev & m_mk) != 8'h00;
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_run++;
        if (rd_data !== it.data || irq !== it.irq) begin
          n_fail++;
          $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                   it.tag, rd_data, irq, it.data, it.irq);
        end
      end
    end
  end

  task automatic expect_rd(input logic sel, input string tag);
    item_t it;
    rd_sel = sel;
    it.data = sel ? m_mk : m_ev;
    it.irq  = m_irq();
    it.tag  = tag;
    sb.push_back(it);
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  // one cycle of stimulus: pulses {txerr,rxdrop,txdone,rxdone}, optional write
  task automatic step(input logic [3:0] p, input logic we, input logic ws, input logic [7:0] d);
    logic [7:0] sv;
    {ev_tx_err, ev_rx_drop, ev_tx_done, ev_rx_done} = p;
    wr_en = we; wr_sel = ws; wr_data = d;
    @(posedge clk); #1;
    {ev_tx_err, ev_rx_drop, ev_tx_done, ev_rx_done} = 4'b0;
    wr_en = 0; wr_data = '0;
    sv = {3'b0, p[3], 1'b0, p[2], p[1], p[0]};
    if (we && ws) m_mk = d & IMPL;
    if (we && !ws) m_ev = m_ev & ~d;
    m_ev = m_ev | sv;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    expect_rd(0, "R1 events after reset");
    expect_rd(1, "R1 mask after reset");

    step(4'b1000, 0, 0, 8'h00);
    expect_rd(0, "R2 R3 tx error sets bit 4, masked");
    step(4'b0000, 1, 1, 8'hFF);
    expect_rd(1, "R6 mask reserved bits read zero");
    expect_rd(0, "R7 R9 irq on enable, events kept");
    step(4'b0100, 0, 0, 8'h00);
    step(4'b0010, 0, 0, 8'h00);
    step(4'b0001, 0, 0, 8'h00);
    expect_rd(0, "R2 all four flags mapped");
    step(4'b0000, 1, 0, 8'h00);
    expect_rd(0, "R4 zero write no effect");
    step(4'b0000, 1, 0, 8'hE8);
    expect_rd(0, "R4 R6 reserved-only clear no effect");
    step(4'b0000, 1, 0, 8'h10);
    expect_rd(0, "R4 clear tx error only");
    step(4'b0000, 1, 1, 8'h02);
    expect_rd(0, "R7 R9 only tx done enabled, events kept");
    step(4'b0000, 1, 0, 8'h05);
    expect_rd(0, "R8 irq holds while enabled flag remains");
    step(4'b0010, 1, 0, 8'h02);
    expect_rd(0, "R5 set wins over clear");
    step(4'b0000, 1, 1, 8'h00);
    expect_rd(0, "R7 R9 masking all drops irq");
    step(4'b0000, 1, 1, 8'h17);
    step(4'b0000, 1, 0, 8'hFF);
    expect_rd(0, "R8 irq falls after all cleared");
    expect_rd(1, "R6 mask readback");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule